// File: doc/BRIEF.md
# Windowed Watchdog Timer with Low-Power Hold

The block is a supervisory counter. It advances on a slow timebase delivered as a one-cycle enable pulse in the system clock domain. If software lets it reach the selected limit, it raises a reset request. Software restarts the count by writing a fixed key byte through a simple write port. The write is honoured only while the refresh window is open, which is the second half of the selected period. A write that is too early, or that carries any other value, counts as a fault and raises the request at once.

A three-bit select picks one of eight limits, each a power of two of timebase periods. A standby flag decides what happens in low-power states. With the flag clear, the count freezes in halt, stop and snooze. It restarts from zero when the device returns to run from halt or stop, but returning from snooze resumes the frozen count. With the flag set, counting carries on regardless of the power state. Both configuration inputs are captured while reset is held and are ignored afterwards. Once raised, the request stays high until the block is reset.

Top module: `wdt_window`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rst_req` is 0 and the count is zero.
- R2: The limit for `cfg_sel` codes 0,1,2,3,4,5,6,7 is 2^6, 2^7, 2^8, 2^9, 2^11, 2^13, 2^14, 2^16 timebase ticks respectively.
- R3: After the limit's worth of `tick_en` pulses since the last restart, `rst_req` rises in the cycle after the final pulse and not before.
- R4: A write of 0xAC while at least half the limit has elapsed since the last restart clears the count to zero without raising `rst_req`.
- R5: A write of 0xAC when fewer than half the limit's ticks have elapsed raises `rst_req` in the next cycle.
- R6: A write of any value other than 0xAC raises `rst_req` in the next cycle.
- R7: With the standby flag 0, ticks arriving while `lp_mode` is halt (2'b01), stop (2'b10) or snooze (2'b11) do not advance the count.
- R8: With the standby flag 0, a change of `lp_mode` from halt or stop to run (2'b00) clears the count. A change from snooze to run keeps it.
- R9: With the standby flag 1, ticks advance the count in every `lp_mode`.
- R10: Once high, `rst_req` stays high until `rst`, whatever the writes and ticks.
- R11: `cfg_sel` and `cfg_stby_run` are sampled only while `rst` is high. Later changes have no effect.
- R12: A valid key write that lands in the same cycle as the limit-reaching tick wins, so `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| tick_en | input | 1 | One-cycle pulse per slow timebase period |
| wr_en | input | 1 | Write strobe for the restart register |
| wr_data | input | 8 | Byte written to the restart register |
| cfg_sel | input | 3 | Limit select code |
| cfg_stby_run | input | 1 | 1: keep counting in low-power states; 0: freeze |
| lp_mode | input | 2 | Power state: 00 run, 01 halt, 10 stop, 11 snooze |
| rst_req | output | 1 | Registered, sticky reset request |

## Verification
The assertions check on every cycle the cycle-level rules: the request is sticky, bad or early writes lead to a request, valid restarts clear the count, the count is frozen in low-power states and cleared on wakeup, it never exceeds the limit, and the captured configuration stays stable. Only the bench scenarios show the eight limits tick by tick, the exact cycle at which an untouched counter fires, and the snooze-versus-halt difference seen at the output. They also show the effect of configuration changes after reset, and the long randomized mixes of ticks, writes and power states checked against a reference model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MAX_EXP = 16;
  localparam int CNT_W   = MAX_EXP;
  localparam int SEL_W   = 3;
  localparam int DATA_W  = 8;
  localparam logic [DATA_W-1:0] KEY_BYTE = 8'hAC;

  typedef enum logic [1:0] {
    LP_RUN    = 2'b00,
    LP_HALT   = 2'b01,
    LP_STOP   = 2'b10,
    LP_SNOOZE = 2'b11
  } lp_mode_e;

  // exponent of the period for each select code
  function automatic int unsigned exp_of(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    return 6;
      3'd1:    return 7;
      3'd2:    return 8;
      3'd3:    return 9;
      3'd4:    return 11;
      3'd5:    return 13;
      3'd6:    return 14;
      default: return 16;
    endcase
  endfunction

  // last count value before overflow (period - 1)
  function automatic logic [CNT_W-1:0] last_of(input logic [SEL_W-1:0] s);
    logic [CNT_W:0] p;
    p = (CNT_W+1)'(1) << exp_of(s);
    return CNT_W'(p - 1'b1);
  endfunction

  // first count value at which the refresh window is open
  function automatic logic [CNT_W-1:0] half_of(input logic [SEL_W-1:0] s);
    return CNT_W'(1) << (exp_of(s) - 1);
  endfunction
endpackage

// File: rtl/wdt_cfg_hold.sv
module wdt_cfg_hold
  import wdt_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel_in,
  input  logic          stby_in,
  output logic [SW-1:0] sel_q,
  output logic          stby_q
);
  // configuration follows the inputs only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= sel_in;
      stby_q <= stby_in;
    end
  end
endmodule

// File: rtl/wdt_lp_track.sv
module wdt_lp_track
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lp_mode_e lp_mode,
  input  logic     stby_run,
  output logic     pause,
  output logic     wake_clr,
  output lp_mode_e lp_prev
);
  logic prev_deep;

  always_ff @(posedge clk) begin
    if (rst) lp_prev <= LP_RUN;
    else     lp_prev <= lp_mode;
  end

  assign prev_deep = (lp_prev == LP_HALT) || (lp_prev == LP_STOP);
  assign pause     = !stby_run && (lp_mode != LP_RUN);
  assign wake_clr  = !stby_run && prev_deep && (lp_mode == LP_RUN);
endmodule

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
  parameter int                DW      = 8,
  parameter logic [DW-1:0]     KEY_VAL = 8'hAC
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          win_open,
  output logic          restart,
  output logic          violation
);
  logic key_match;
  assign key_match = (wr_data == KEY_VAL);
  assign restart   = wr_en && key_match && win_open;
  assign violation = wr_en && !(key_match && win_open);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pause,
  input  logic          clr,
  input  logic          hold,
  input  logic [SW-1:0] sel,
  output logic [CW-1:0] cnt,
  output logic          win_open,
  output logic          ovf_hit
);
  logic [CW-1:0] last_v;
  logic [CW-1:0] half_v;
  logic          adv;

  assign last_v = last_of(sel);
  assign half_v = half_of(sel);
  assign adv    = tick && !pause;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!hold) begin
      if (clr)                       cnt <= '0;
      else if (adv && cnt != last_v) cnt <= cnt + 1'b1;
    end
  end

  assign win_open = (cnt >= half_v);
  assign ovf_hit  = !hold && !clr && adv && (cnt == last_v);
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int                 DW      = DATA_W,
  parameter logic [DW-1:0]      KEY_VAL = KEY_BYTE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    cfg_sel,
  input  logic          cfg_stby_run,
  input  logic [1:0]    lp_mode,
  output logic          rst_req
);
  logic [SEL_W-1:0] sel_q;
  logic             stby_q;
  logic             pause, wake_clr;
  lp_mode_e         lp_prev;
  logic [CNT_W-1:0] cnt;
  logic             win_open, ovf_hit;
  logic             restart, violation;
  logic             req_q;

  wdt_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .sel_in(cfg_sel), .stby_in(cfg_stby_run),
    .sel_q(sel_q), .stby_q(stby_q)
  );

  wdt_lp_track u_lp (
    .clk(clk), .rst(rst), .lp_mode(lp_mode_e'(lp_mode)), .stby_run(stby_q),
    .pause(pause), .wake_clr(wake_clr), .lp_prev(lp_prev)
  );

  wdt_key_gate #(.DW(DW), .KEY_VAL(KEY_VAL)) u_key (
    .wr_en(wr_en), .wr_data(wr_data), .win_open(win_open),
    .restart(restart), .violation(violation)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .pause(pause),
    .clr(restart || wake_clr), .hold(req_q), .sel(sel_q),
    .cnt(cnt), .win_open(win_open), .ovf_hit(ovf_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)                       req_q <= 1'b0;
    else if (ovf_hit || violation) req_q <= 1'b1;
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [1:0]       lp_mode,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] sel_q,
  input logic             stby_q,
  input lp_mode_e         lp_prev
);
  p_req_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);

  p_bad_value_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data != KEY_BYTE) |=> rst_req);

  p_early_key_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == KEY_BYTE && cnt < half_of(sel_q)) |=> rst_req);

  p_key_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && wr_en && wr_data == KEY_BYTE && cnt >= half_of(sel_q))
      |=> (cnt == '0 && !rst_req));

  p_lp_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && !stby_q && lp_mode != 2'b00 && !wr_en) |=> $stable(cnt));

  p_wake_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && !stby_q && (lp_prev == LP_HALT || lp_prev == LP_STOP)
     && lp_mode == 2'b00) |=> (cnt == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_of(sel_q));

  p_cfg_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(sel_q) && $stable(stby_q)));
endmodule

bind wdt_window wdt_window_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .lp_mode(lp_mode),
  .rst_req(rst_req), .cnt(cnt), .sel_q(sel_q), .stby_q(stby_q), .lp_prev(lp_prev)
);

// File: tb/tb_wdt_window.sv
module tb_wdt_window;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] cfg_sel = 3'd0;
  logic       cfg_stby_run = 1'b0;
  logic [1:0] lp_mode = 2'b00;
  logic       rst_req;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int   m_cnt = 0;
  bit   m_req = 0;
  logic [1:0] m_lpp = 2'b00;
  int   m_sel = 0;
  bit   m_stby = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  wdt_window dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_sel(cfg_sel), .cfg_stby_run(cfg_stby_run), .lp_mode(lp_mode),
    .rst_req(rst_req)
  );

  function automatic int period(input int s);
    int e;
    case (s)
      0: e = 6;  1: e = 7;  2: e = 8;  3: e = 9;
      4: e = 11; 5: e = 13; 6: e = 14; default: e = 16;
    endcase
    return 1 << e;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rst_req actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit t, input bit w, input logic [7:0] d);
    bit pause, wake;
    pause = !m_stby && (lp_mode != 2'b00);
    wake  = !m_stby && (m_lpp == 2'b01 || m_lpp == 2'b10) && (lp_mode == 2'b00);
    if (!m_req) begin
      if (w && d != 8'hAC)                      m_req = 1;
      else if (w && m_cnt < period(m_sel) / 2)  m_req = 1;
      else if (w || wake)                       m_cnt = 0;
      else if (t && !pause) begin
        if (m_cnt == period(m_sel) - 1) m_req = 1;
        else                            m_cnt++;
      end
    end
    m_lpp = lp_mode;
  endtask

  task automatic cyc(input bit t, input bit w, input logic [7:0] d);
    tick_en = t; wr_en = w; wr_data = d;
    model_step(t, w, d);
    @(posedge clk); #1;
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h00);
  endtask

  task automatic do_reset(input int s, input bit st);
    cfg_sel = 3'(s); cfg_stby_run = st; lp_mode = 2'b00; rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R1 during reset", rst_req, 1'b0);
    rst = 1'b0;
    m_cnt = 0; m_req = 0; m_lpp = 2'b00; m_sel = s; m_stby = st;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R1 / R2 / R3: each limit, fires one cycle after the last tick
    for (int s = 0; s < 8; s++) begin
      do_reset(s, 0);
      cyc(0, 0, 8'h00);
      chk("R1 after reset", rst_req, 1'b0);
      ticks(period(s) - 1);
      chk("R2 no req before limit", rst_req, 1'b0);
      ticks(1);
      chk("R3 req at limit", rst_req, 1'b1);
    end

    // R4: key at exactly half restarts
    do_reset(0, 0);
    ticks(32); cyc(0, 1, 8'hAC);
    chk("R4 valid key no req", rst_req, 1'b0);
    ticks(63); chk("R4 restarted count", rst_req, 1'b0);
    ticks(1);  chk("R4 overflow after restart", rst_req, 1'b1);

    // R5: key one tick before the window
    do_reset(0, 0);
    ticks(31); cyc(0, 1, 8'hAC);
    chk("R5 early key", rst_req, 1'b1);

    // R6: wrong value inside the window
    do_reset(1, 0);
    ticks(100); cyc(0, 1, 8'h55);
    chk("R6 wrong value", rst_req, 1'b1);

    // R10: sticky
    for (int i = 0; i < 20; i++) cyc(1, 1, 8'hAC);
    chk("R10 sticky after writes", rst_req, 1'b1);

    // R7 / R8: halt freezes, wake clears
    do_reset(0, 0);
    ticks(40); lp_mode = 2'b01; ticks(100);
    chk("R7 frozen in halt", rst_req, 1'b0);
    lp_mode = 2'b00; cyc(0, 0, 8'h00);
    ticks(63); chk("R8 halt wake cleared", rst_req, 1'b0);
    ticks(1);  chk("R8 limit after wake", rst_req, 1'b1);

    // R7 / R8: stop behaves like halt
    do_reset(0, 0);
    ticks(50); lp_mode = 2'b10; ticks(80);
    lp_mode = 2'b00; cyc(0, 0, 8'h00);
    ticks(63); chk("R8 stop wake cleared", rst_req, 1'b0);

    // R7 / R8: snooze freezes but keeps the count
    do_reset(0, 0);
    ticks(40); lp_mode = 2'b11; ticks(90);
    chk("R7 frozen in snooze", rst_req, 1'b0);
    lp_mode = 2'b00; cyc(0, 0, 8'h00);
    ticks(23); chk("R8 snooze kept count", rst_req, 1'b0);
    ticks(1);  chk("R8 snooze limit", rst_req, 1'b1);

    // R9: standby flag set keeps counting
    do_reset(0, 1);
    ticks(10); lp_mode = 2'b01; ticks(53);
    chk("R9 counting in halt", rst_req, 1'b0);
    ticks(1); chk("R9 limit in halt", rst_req, 1'b1);

    // R11: configuration changes after reset ignored
    do_reset(0, 0);
    cfg_sel = 3'd7; cfg_stby_run = 1'b1;
    ticks(63); chk("R11 sel held", rst_req, 1'b0);
    lp_mode = 2'b01; ticks(20);
    chk("R11 stby held frozen", rst_req, 1'b0);
    lp_mode = 2'b00; cyc(0, 0, 8'h00);
    ticks(64); chk("R11 period 64 kept", rst_req, 1'b1);

    // R12: key beats the limit-reaching tick
    do_reset(0, 0);
    ticks(63); cyc(1, 1, 8'hAC);
    chk("R12 key wins", rst_req, 1'b0);
    ticks(63); chk("R12 restarted", rst_req, 1'b0);
    ticks(1);  chk("R12 limit after", rst_req, 1'b1);

    // random mix against the model
    do_reset(0, 0);
    for (int i = 0; i < 6000; i++) begin
      bit t, w;
      logic [7:0] d;
      if (m_req && ($urandom % 20 == 0)) do_reset(int'($urandom % 4), bit'($urandom % 2));
      if ($urandom % 40 == 0) lp_mode = 2'($urandom % 4);
      t = bit'($urandom % 2);
      w = 1'b0; d = 8'hAC;
      if (m_cnt >= period(m_sel) / 2 && ($urandom % 8 == 0)) w = 1'b1;
      if ($urandom % 300 == 0) begin
        w = 1'b1;
        if ($urandom % 2 == 0) d = 8'($urandom);
      end
      cyc(t, w, d);
      chk("R3 random model", rst_req, m_req);
    end

    done = 1;
    finish_run();
  end
endmodule